// File: doc/BRIEF.md
# Linked-list descriptor queue manager

This block holds a set of hardware packet queues. None of the queues has its own FIFO storage. Every queue is a chain of descriptor indices kept in one link RAM that all queues share. The RAM is indexed by descriptor number, and each entry holds the index of the next descriptor in the same queue. For each queue the block keeps only a head index, a tail index and an entry count.

Software works through a small register bus that has one write channel and one read channel:

- Writing a descriptor's byte address to a queue's push location appends that descriptor to the queue.
- Reading the queue's pop location removes the head descriptor and returns its byte address one cycle later.
- A third location per queue returns the queue's entry count.
- One shared location reads and clears a sticky error flag.

One descriptor region is set up through static configuration inputs: a base byte address, a descriptor count, a power-of-two descriptor size and the link index of the first descriptor. Byte addresses are converted to link indices and back using this region. The queues are numbered from the parameter `Q_BASE` and cover `NUM_Q` consecutive queue numbers.

Top module: `qm_desc_queue_mgr`

## Requirements
- R1: A push to an empty queue makes its count 1, and the next pop of that queue returns the pushed address.
- R2: Each queue returns its descriptors in the order they were pushed. Its count equals pushes minus pops and never exceeds `LINK_DEPTH`.
- R3: Queues are independent. A read with select 2 returns the addressed queue's entry count in the low bits. Bus address = {select[1:0], queue number[QID_W-1:0]}.
- R4: A pop (read, select 1) from an empty queue returns 0 and leaves that queue's count at 0.
- R5: The link index of a descriptor is start + (addr − base) >> size_log2. A pop converts the index back to a byte address, so the address returned always equals the address pushed. This holds for every slot of the region, including the first and the last.
- R6: A push (write, select 0) is dropped and sets the sticky error flag in any of these cases: the address is below the base, the address is not aligned to the descriptor size, the slot is not below the descriptor count, or the link index falls outside the link RAM. The count of the target queue does not change. The flag reads back as bit 0 at select 3.
- R7: The error flag stays set until a write to select 3 with data bit 0 = 1 clears it.
- R8: A push and a pop to the same queue in the same cycle act as push first, then pop. On an empty queue the pop returns the address being pushed, and the queue stays empty.
- R9: A queue number outside [Q_BASE, Q_BASE+NUM_Q) is handled as follows. A push to it is dropped and sets the error flag. Reads of it return 0.
- R10: `rd_valid` is high exactly in the cycle after `rd_en`, with `rd_data` registered in that cycle. Reads at select 0 return 0.
- R11: After reset every queue count is 0 and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_region_base | input | ADDR_W | Byte address of the first descriptor |
| cfg_desc_count | input | CNT_W | Number of descriptors in the region |
| cfg_size_log2 | input | SZ_W | log2 of the descriptor size in bytes |
| cfg_link_start | input | IDX_W | Link index of the first descriptor |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | QID_W+2 | Write address {select, queue number} |
| wr_data | input | ADDR_W | Descriptor address, or clear bit for select 3 |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | QID_W+2 | Read address {select, queue number} |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | ADDR_W | Read result |
| err_flag | output | 1 | Sticky error flag for dropped pushes |

## Verification
The assertions check the following on every cycle:
- the one-cycle read timing;
- that a rejected push always raises the flag, and that the flag holds until it is cleared;
- that a push into an empty queue gives a count of 1 with the head at the new index;
- that a pop of an empty queue leaves the count at 0;
- that no count exceeds the link depth.

FIFO ordering across interleaved queues, the round trip from address to index and back for every region slot, and the push-before-pop ordering in one cycle all depend on a history of accesses. Only the bench scenarios can show these. They are compared against a queue model kept in the bench.

// File: rtl/qm_pkg.sv
// Package: shared bus select codes for the descriptor queue manager.
// Assumes the select field is the top two bits of each bus address.
package qm_pkg;
    typedef enum logic [1:0] {
        SEL_PUSH  = 2'd0,
        SEL_POP   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_ERR   = 2'd3
    } bus_sel_e;
endpackage

// File: rtl/qm_addr_xlate.sv
// Module: converts descriptor byte addresses to link indices and back,
// for one region. Assumes the descriptor size is a power of two and that
// the configuration stays static while the queues are in use.
module qm_addr_xlate #(
    parameter int ADDR_W     = 32,
    parameter int LINK_DEPTH = 256,
    localparam int IDX_W     = $clog2(LINK_DEPTH),
    localparam int CNT_W     = $clog2(LINK_DEPTH + 1),
    localparam int SZ_W      = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] cfg_region_base,
    input  logic [CNT_W-1:0]  cfg_desc_count,
    input  logic [SZ_W-1:0]   cfg_size_log2,
    input  logic [IDX_W-1:0]  cfg_link_start,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              idx_ok,
    output logic [IDX_W-1:0]  idx_out,
    input  logic [IDX_W-1:0]  idx_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] idx_wide;
    logic              above_base, aligned, in_count, in_ram;

    // Forward path: range check and slot number for a pushed address.
    always_comb begin
        above_base = addr_in >= cfg_region_base;
        offset     = addr_in - cfg_region_base;
        align_mask = (ADDR_W'(1) << cfg_size_log2) - ADDR_W'(1);
        aligned    = (offset & align_mask) == '0;
        slot       = offset >> cfg_size_log2;
        in_count   = slot < ADDR_W'(cfg_desc_count);
        idx_wide   = ADDR_W'(cfg_link_start) + slot;
        in_ram     = idx_wide < ADDR_W'(LINK_DEPTH);
        idx_ok     = above_base && aligned && in_count && in_ram;
        idx_out    = idx_wide[IDX_W-1:0];
    end

    // Reverse path: byte address of a popped link index.
    always_comb begin
        addr_out = cfg_region_base
                 + ((ADDR_W'(idx_in) - ADDR_W'(cfg_link_start)) << cfg_size_log2);
    end
endmodule

// File: rtl/qm_link_ram.sv
// Module: shared next-pointer storage, one entry per descriptor index.
// It has one synchronous write port and one combinational read port. Entries
// are not reset; an entry is only read after a push has written it.
module qm_link_ram #(
    parameter int LINK_DEPTH = 256,
    localparam int IDX_W     = $clog2(LINK_DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] wr_next,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] rd_next
);
    logic [IDX_W-1:0] mem [LINK_DEPTH];

    // Store the successor of a descriptor when a push appends behind it.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_next;
    end

    // Successor lookup for the queue head being popped.
    always_comb rd_next = mem[rd_idx];
endmodule

// File: rtl/qm_queue_state.sv
// Module: per-queue head, tail and count registers, plus the link update.
// Assumes no descriptor index sits in more than one queue at a time.
// A push and a pop in the same cycle act as push first, then pop.
module qm_queue_state #(
    parameter int NUM_Q      = 32,
    parameter int LINK_DEPTH = 256,
    localparam int QSEL_W    = $clog2(NUM_Q),
    localparam int IDX_W     = $clog2(LINK_DEPTH),
    localparam int CNT_W     = $clog2(LINK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [QSEL_W-1:0] push_q,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop_en,
    input  logic [QSEL_W-1:0] pop_q,
    output logic              pop_hit,
    output logic [IDX_W-1:0]  pop_idx,
    input  logic [QSEL_W-1:0] cnt_q,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              link_wr_en,
    output logic [IDX_W-1:0]  link_wr_idx,
    output logic [IDX_W-1:0]  link_wr_next,
    output logic [IDX_W-1:0]  link_rd_idx,
    input  logic [IDX_W-1:0]  link_rd_next
);
    logic [IDX_W-1:0] head [NUM_Q];
    logic [IDX_W-1:0] tail [NUM_Q];
    logic [CNT_W-1:0] cnt  [NUM_Q];

    logic             same_q;
    logic [IDX_W-1:0] next_head;

    // Pop decision: it sees the queue as it is after this cycle's push.
    always_comb begin
        same_q      = push_en && pop_en && (push_q == pop_q);
        pop_hit     = pop_en && ((cnt[pop_q] != '0) || same_q);
        pop_idx     = (cnt[pop_q] == '0) ? push_idx : head[pop_q];
        link_rd_idx = head[pop_q];
        next_head   = (same_q && cnt[pop_q] == CNT_W'(1)) ? push_idx : link_rd_next;
    end

    // Link write: chain the new descriptor behind the current tail.
    always_comb begin
        link_wr_en   = push_en && (cnt[push_q] != '0);
        link_wr_idx  = tail[push_q];
        link_wr_next = push_idx;
    end

    // Count readout for status reads.
    always_comb cnt_out = cnt[cnt_q];

    // Per-queue register update.
    always_ff @(posedge clk) begin
        for (int q = 0; q < NUM_Q; q++) begin
            if (!rst_n) begin
                head[q] <= '0;
                tail[q] <= '0;
                cnt[q]  <= '0;
            end else begin
                logic inc, dec;
                inc = push_en && (push_q == QSEL_W'(q));
                dec = pop_hit && (pop_q == QSEL_W'(q));
                if (inc) tail[q] <= push_idx;
                if (dec && cnt[q] != '0)
                    head[q] <= next_head;
                else if (inc && cnt[q] == '0)
                    head[q] <= push_idx;
                cnt[q] <= cnt[q] + CNT_W'(inc) - CNT_W'(dec);
            end
        end
    end

    // R1
    push_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !same_q && cnt[push_q] == '0)
        |=> (cnt[$past(push_q)] == CNT_W'(1) && head[$past(push_q)] == $past(push_idx)));

    // R4
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !same_q && cnt[pop_q] == '0) |=> (cnt[$past(pop_q)] == '0));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_bound
        // R2
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] <= CNT_W'(LINK_DEPTH));
    end
endmodule

// File: rtl/qm_desc_queue_mgr.sv
// Module: top of the descriptor queue manager. Decodes the register bus
// into push, pop, count and error accesses and registers the read data.
// Assumes bus address = {select[1:0], queue number[QID_W-1:0]} and that
// the region configuration is static.
module qm_desc_queue_mgr #(
    parameter int ADDR_W     = 32,
    parameter int NUM_Q      = 32,
    parameter int LINK_DEPTH = 256,
    parameter int QID_W      = 16,
    parameter int Q_BASE     = 0,
    localparam int IDX_W     = $clog2(LINK_DEPTH),
    localparam int CNT_W     = $clog2(LINK_DEPTH + 1),
    localparam int SZ_W      = $clog2(ADDR_W),
    localparam int BUS_AW    = QID_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_region_base,
    input  logic [CNT_W-1:0]  cfg_desc_count,
    input  logic [SZ_W-1:0]   cfg_size_log2,
    input  logic [IDX_W-1:0]  cfg_link_start,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] rd_addr,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_data,
    output logic              err_flag
);
    import qm_pkg::*;

    localparam int QSEL_W = $clog2(NUM_Q);
    localparam logic [QID_W-1:0] QB = QID_W'(Q_BASE);

    bus_sel_e          wr_sel, rd_sel;
    logic [QID_W-1:0]  wr_off, rd_off;
    logic              wr_q_in, rd_q_in;
    logic              push_req, push_ok, push_bad, err_clr;
    logic              pop_en, pop_hit, idx_ok, link_wr_en;
    logic [IDX_W-1:0]  push_idx, pop_idx;
    logic [IDX_W-1:0]  link_wr_idx, link_wr_next, link_rd_idx, link_rd_next;
    logic [CNT_W-1:0]  cnt_out;
    logic [ADDR_W-1:0] pop_addr, rd_next;

    // Bus decode: select field and queue number relative to the base.
    always_comb begin
        wr_sel   = bus_sel_e'(wr_addr[QID_W +: 2]);
        rd_sel   = bus_sel_e'(rd_addr[QID_W +: 2]);
        wr_off   = wr_addr[QID_W-1:0] - QB;
        rd_off   = rd_addr[QID_W-1:0] - QB;
        wr_q_in  = wr_off < QID_W'(NUM_Q);
        rd_q_in  = rd_off < QID_W'(NUM_Q);
        push_req = wr_en && (wr_sel == SEL_PUSH);
        push_ok  = push_req && wr_q_in && idx_ok;
        push_bad = push_req && !push_ok;
        err_clr  = wr_en && (wr_sel == SEL_ERR) && wr_data[0];
        pop_en   = rd_en && (rd_sel == SEL_POP) && rd_q_in;
    end

    qm_addr_xlate #(.ADDR_W(ADDR_W), .LINK_DEPTH(LINK_DEPTH)) xlate_i (
        .cfg_region_base (cfg_region_base),
        .cfg_desc_count  (cfg_desc_count),
        .cfg_size_log2   (cfg_size_log2),
        .cfg_link_start  (cfg_link_start),
        .addr_in         (wr_data),
        .idx_ok          (idx_ok),
        .idx_out         (push_idx),
        .idx_in          (pop_idx),
        .addr_out        (pop_addr)
    );

    qm_queue_state #(.NUM_Q(NUM_Q), .LINK_DEPTH(LINK_DEPTH)) state_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_en      (push_ok),
        .push_q       (wr_off[QSEL_W-1:0]),
        .push_idx     (push_idx),
        .pop_en       (pop_en),
        .pop_q        (rd_off[QSEL_W-1:0]),
        .pop_hit      (pop_hit),
        .pop_idx      (pop_idx),
        .cnt_q        (rd_off[QSEL_W-1:0]),
        .cnt_out      (cnt_out),
        .link_wr_en   (link_wr_en),
        .link_wr_idx  (link_wr_idx),
        .link_wr_next (link_wr_next),
        .link_rd_idx  (link_rd_idx),
        .link_rd_next (link_rd_next)
    );

    qm_link_ram #(.LINK_DEPTH(LINK_DEPTH)) link_i (
        .clk     (clk),
        .wr_en   (link_wr_en),
        .wr_idx  (link_wr_idx),
        .wr_next (link_wr_next),
        .rd_idx  (link_rd_idx),
        .rd_next (link_rd_next)
    );

    // Read multiplexer: pop address, count or error flag.
    always_comb begin
        rd_next = '0;
        unique case (rd_sel)
            SEL_POP:   if (pop_hit) rd_next = pop_addr;
            SEL_COUNT: if (rd_q_in) rd_next = ADDR_W'(cnt_out);
            SEL_ERR:   rd_next = ADDR_W'(err_flag);
            default:   rd_next = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_next : '0;
        end
    end

    // Sticky error flag: set by a dropped push, cleared by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (push_bad) err_flag <= 1'b1;
        else if (err_clr)  err_flag <= 1'b0;
    end

    // R10
    rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R6
    bad_push_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_bad |=> err_flag);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: tb/qm_desc_queue_mgr_tb_top.sv
// Bench: sweeps a small configuration (4 queues, 16 link entries, 12
// descriptors of 64 bytes) against a queue model kept in the bench.
module qm_desc_queue_mgr_tb_top;
    localparam int NQ = 4, DEP = 16, QB = 8, QW = 16, AW = 32;
    localparam logic [31:0] BASE = 32'h1000;
    localparam int SZL = 6, DCNT = 12, START = 2;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [QW+1:0] wr_addr = '0, rd_addr = '0;
    logic [AW-1:0] wr_data = '0;
    logic rd_valid, err_flag;
    logic [AW-1:0] rd_data;
    int n_cmp = 0, n_bad = 0;
    logic got_v;
    logic [31:0] got_d;
    logic [31:0] mq [NQ][$];

    always #2 clk = ~clk;

    qm_desc_queue_mgr #(.ADDR_W(AW), .NUM_Q(NQ), .LINK_DEPTH(DEP),
                        .QID_W(QW), .Q_BASE(QB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_region_base(BASE), .cfg_desc_count(5'(DCNT)),
        .cfg_size_log2(5'(SZL)), .cfg_link_start(4'(START)),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_flag(err_flag));

    function automatic logic [31:0] addr_of(int s);
        return BASE + 32'(s * 64);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle; the outputs are sampled 1 ns after the edge.
    task automatic cyc(bit we, logic [1:0] ws, int wq, logic [31:0] wd,
                       bit re, logic [1:0] rs, int rq);
        wr_en = we; wr_addr = {ws, QW'(wq)}; wr_data = wd;
        rd_en = re; rd_addr = {rs, QW'(rq)};
        @(posedge clk); #1;
        got_v = rd_valid; got_d = rd_data;
        wr_en = 0; rd_en = 0;
    endtask

    function automatic bit push_legal(int q, logic [31:0] a);
        if (q < QB || q >= QB + NQ) return 0;
        if (a < BASE) return 0;
        if (((a - BASE) % 64) != 0) return 0;
        return ((a - BASE) / 64) < DCNT;
    endfunction

    task automatic push(int q, logic [31:0] a);
        cyc(1, 2'd0, q, a, 0, 2'd0, 0);
        if (push_legal(q, a)) mq[q-QB].push_back(a);
    endtask

    task automatic pop_chk(int q, string tag);
        logic [31:0] exp;
        exp = 0;
        if (q >= QB && q < QB + NQ && mq[q-QB].size() > 0) exp = mq[q-QB].pop_front();
        cyc(0, 2'd0, 0, 0, 1, 2'd1, q);
        chk(got_v && got_d == exp, tag, got_d, exp);
    endtask

    task automatic cnt_chk(int q, string tag);
        logic [31:0] exp;
        exp = (q >= QB && q < QB + NQ) ? 32'(mq[q-QB].size()) : 0;
        cyc(0, 2'd0, 0, 0, 1, 2'd2, q);
        chk(got_v && got_d == exp, tag, got_d, exp);
    endtask

    task automatic err_chk(bit exp, string tag);
        cyc(0, 2'd0, 0, 0, 1, 2'd3, 0);
        chk(got_v && got_d == 32'(exp) && err_flag == exp, tag, got_d, 32'(exp));
    endtask

    task automatic err_clear();
        cyc(1, 2'd3, 0, 32'h1, 0, 2'd0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R11: reset state
        for (int q = QB; q < QB + NQ; q++) cnt_chk(q, "R11 count after reset");
        err_chk(0, "R11 error flag after reset");

        // R4: pop every empty queue
        for (int q = QB; q < QB + NQ; q++) begin
            pop_chk(q, "R4 pop empty");
            cnt_chk(q, "R4 count stays 0");
        end

        // R10: idle cycle has no valid; a select-0 read returns 0
        cyc(0, 2'd0, 0, 0, 0, 2'd0, 0);
        chk(got_v == 0, "R10 idle valid", 32'(got_v), 0);
        cyc(0, 2'd0, 0, 0, 1, 2'd0, QB);
        chk(got_v == 1 && got_d == 0, "R10 select-0 read", got_d, 0);

        // R3 R5 R2: every slot, round robin over the queues
        for (int s = 0; s < DCNT; s++) push(QB + (s % NQ), addr_of(s));
        for (int q = QB; q < QB + NQ; q++) cnt_chk(q, "R3 per-queue count");
        for (int q = QB; q < QB + NQ; q++)
            for (int k = 0; k < DCNT / NQ; k++) pop_chk(q, "R5 R2 round-robin order");
        err_chk(0, "R5 legal pushes raise no error");

        // R2 R5: all slots into one queue in descending order, interleaved pops
        for (int s = DCNT - 1; s >= 0; s--) push(QB + 2, addr_of(s));
        cnt_chk(QB + 2, "R2 full count");
        for (int k = 0; k < 4; k++) pop_chk(QB + 2, "R2 partial drain");
        push(QB + 2, addr_of(0));
        push(QB + 1, addr_of(1));
        cnt_chk(QB + 2, "R2 count after refill");
        while (mq[2].size() > 0) pop_chk(QB + 2, "R2 descending order");
        pop_chk(QB + 1, "R1 single entry");
        pop_chk(QB + 2, "R4 drained queue");

        // R1: push to an empty queue, count 1, then pop
        push(QB + 3, addr_of(DCNT - 1));
        cnt_chk(QB + 3, "R1 count is 1");
        pop_chk(QB + 3, "R1 pop returns pushed");

        // R8: push and pop in one cycle, empty queue
        cyc(1, 2'd0, QB, addr_of(5), 1, 2'd1, QB);
        chk(got_v && got_d == addr_of(5), "R8 empty same-cycle", got_d, addr_of(5));
        cnt_chk(QB, "R8 queue stays empty");
        // R8: one entry, then two entries
        push(QB, addr_of(6));
        cyc(1, 2'd0, QB, addr_of(7), 1, 2'd1, QB);
        chk(got_d == addr_of(6), "R8 one-entry same-cycle", got_d, addr_of(6));
        void'(mq[0].pop_front()); mq[0].push_back(addr_of(7));
        cnt_chk(QB, "R8 count after one-entry case");
        push(QB, addr_of(8));
        cyc(1, 2'd0, QB, addr_of(9), 1, 2'd1, QB);
        chk(got_d == addr_of(7), "R8 two-entry same-cycle", got_d, addr_of(7));
        void'(mq[0].pop_front()); mq[0].push_back(addr_of(9));
        pop_chk(QB, "R8 order after same-cycle");
        pop_chk(QB, "R8 order after same-cycle");
        pop_chk(QB, "R8 now empty");
        // R8: push and pop in one cycle to different queues
        push(QB + 1, addr_of(3));
        cyc(1, 2'd0, QB + 2, addr_of(4), 1, 2'd1, QB + 1);
        chk(got_d == addr_of(3), "R8 different queues", got_d, addr_of(3));
        void'(mq[1].pop_front()); mq[2].push_back(addr_of(4));
        pop_chk(QB + 2, "R8 other queue kept its push");

        // R6 R7: each illegal address on its own
        begin
            logic [31:0] bad [4];
            bad[0] = BASE + 1; bad[1] = BASE - 64;
            bad[2] = addr_of(DCNT); bad[3] = BASE + 32;
            for (int i = 0; i < 4; i++) begin
                err_clear();
                err_chk(0, "R7 cleared");
                push(QB + 1, bad[i]);
                err_chk(1, "R6 flag set");
                cnt_chk(QB + 1, "R6 count unchanged");
                cyc(0, 2'd0, 0, 0, 0, 2'd0, 0);
                err_chk(1, "R7 flag sticky");
            end
        end
        // R9: queue numbers outside the range
        for (int q = QB - 1; q <= QB + NQ; q += NQ + 1) begin
            err_clear();
            push(q, addr_of(0));
            err_chk(1, "R9 out-of-range push flags");
            cnt_chk(q, "R9 out-of-range count reads 0");
            pop_chk(q, "R9 out-of-range pop reads 0");
        end
        for (int q = QB; q < QB + NQ; q++) cnt_chk(q, "R9 in-range queues untouched");
        err_clear();
        err_chk(0, "R7 final clear");

        summary();
        $finish;
    end
endmodule